// File: doc/BRIEF.md
# MDIO Management Host Controller

This block is a register-programmed master for the two-wire PHY management bus (clause-22 frames only). Software programs a command word holding the PHY register number, the PHY address and the direction, plus a 16-bit write value, and then writes the control word with the go and enable bits set. The controller then sends one complete 64-bit management frame on MDC/MDIO. For a read, it releases MDIO from the turnaround onwards and shifts in 16 data bits. When the frame ends it drops the busy indication, and the read value is ready in the read-data register in that same cycle.

The register bus is a plain single-cycle write port with a combinational read path. It has no handshake: every write is taken in the cycle it is presented. MDC comes from the system clock. Each half period lasts a whole number of system cycles, computed from the clock rate and a ceiling on the MDC rate (2.5 MHz by default). MDC stays low whenever no frame is in flight. MDIO is modelled as separate output, output-enable and input pins. The board supplies a pull-up, so a PHY address with no device behind it reads as all ones.

Top module: `mgmt_mdio_ctrl`

## Requirements
- R1: After reset, all four registers read 0, MDC is low and the MDIO output enable is low.
- R2: Word offsets are command 0x0, write data 0x4, read data 0x8 and control 0xC. The command word keeps bits 10:0: register number in 4:0, PHY address in 9:5, and bit 10 = 1 for read or 0 for write. Write data keeps bits 15:0. Read data is read-only. Unused bits read 0.
- R3: A control write with bit 0 (go) and bit 3 (enable) both 1 while idle starts a frame. From the next cycle, control reads bit 0 = 1 until the frame ends. Bit 3 reads back the last enable value written.
- R4: A write frame, in transmit order, is 32 ones, 01, opcode 01, the 5-bit PHY address, the 5-bit register number, 10, and then the 16 data bits MSB first. The output enable is high for all 64 bits.
- R5: A read frame sends opcode 10 and drives MDIO only for bit positions 0 to 45. It samples mdio_in on the MDC rising edges of bits 48 to 63, MSB first. The result appears in read data (bits 15:0) in the same cycle that busy clears.
- R6: A read from a PHY address where no device answers returns 0xFFFF.
- R7: Each MDC half period lasts HALF = ceil(CLK_HZ / (2*MDC_MAX_HZ)) system cycles, and each frame has exactly 64 MDC rising edges. Busy clears exactly 128*HALF cycles after the accepting clock edge, on the last falling edge of MDC.
- R8: A go request made while a frame is in flight has no effect. The frame in flight keeps the command and data latched when it started, and no second frame follows.
- R9: A control write with go = 1 and enable = 0 starts nothing: busy stays 0 and MDC does not toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, taken on the clock edge |
| reg_addr | input | 4 | Byte address; bits 3:2 select the word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_in | input | 1 | MDIO line value as seen at the pin |

## Verification
Busy is due one edge after the accepting control write. It is due low exactly 128*HALF edges after that write. The bench samples control on the falling clock edge just before and just after that boundary, so a frame that ends one cycle early or late fails. Read data must be valid in the first cycle that busy reads 0, so it is read straight after the boundary check. The bench reads MDIO line values on the MDC rising edges and decodes them with a small PHY model. Once the 64th rise has occurred it compares the whole header and the output-enable history against a frame built by a bench function.

// File: rtl/mdio_ctrl_pkg.sv
package mdio_ctrl_pkg;

  localparam int unsigned FRAME_BITS = 64;
  localparam int unsigned PRE_BITS   = 32;
  localparam int unsigned TA_POS     = 46;
  localparam int unsigned DATA_POS   = 48;
  localparam int unsigned DATA_W     = 16;

  localparam logic [1:0] WORD_CMD  = 2'd0;
  localparam logic [1:0] WORD_WDAT = 2'd1;
  localparam logic [1:0] WORD_RDAT = 2'd2;
  localparam logic [1:0] WORD_CTRL = 2'd3;

  localparam int unsigned CMD_OP_BIT  = 10;
  localparam int unsigned CMD_PHY_LSB = 5;
  localparam int unsigned CTRL_GO_BIT = 0;
  localparam int unsigned CTRL_EN_BIT = 3;

  typedef struct packed {
    logic              rd;
    logic [4:0]        phy;
    logic [4:0]        regnum;
    logic [DATA_W-1:0] wdata;
  } mdio_cmd_t;

  // Frame bits after the preamble, first transmitted bit in [31].
  function automatic logic [31:0] frame_tail(input mdio_cmd_t c);
    logic [1:0] op;
    logic [1:0] ta;
    op = c.rd ? 2'b10 : 2'b01;
    ta = c.rd ? 2'b11 : 2'b10;
    return {2'b01, op, c.phy, c.regnum, ta, (c.rd ? 16'hFFFF : c.wdata)};
  endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int unsigned HALF = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int unsigned HW = (HALF < 2) ? 2 : HALF;
  localparam int unsigned CW = $clog2(HW);

  logic [CW-1:0] cnt;
  logic          last;

  assign last = (cnt == CW'(HW - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (last) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // Events mark the cycle whose closing edge moves MDC.
  assign rise_ev = run & last & ~mdc;
  assign fall_ev = run & last & mdc;
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mdio_cmd_t         cmd_in,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              mdio_in,
  output logic              busy,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic              rd_load,
  output logic [DATA_W-1:0] rd_word
);
  localparam logic [5:0] LAST_IDX = 6'(FRAME_BITS - 1);
  localparam logic [5:0] PRE_IDX  = 6'(PRE_BITS);
  localparam logic [5:0] TA_IDX   = 6'(TA_POS);
  localparam logic [5:0] DAT_IDX  = 6'(DATA_POS);

  mdio_cmd_t         cmd_q;
  logic [5:0]        idx;
  logic [DATA_W-1:0] shreg;
  logic [31:0]       tail;
  logic [5:0]        tail_pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      shreg <= '0;
      cmd_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        idx   <= '0;
        cmd_q <= cmd_in;
      end
    end else begin
      if (rise_ev && cmd_q.rd && idx >= DAT_IDX) begin
        shreg <= {shreg[DATA_W-2:0], mdio_in};
      end
      if (fall_ev) begin
        if (idx == LAST_IDX) begin
          busy <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  assign tail     = frame_tail(cmd_q);
  assign tail_pos = LAST_IDX - idx;

  always_comb begin
    if (!busy || idx < PRE_IDX) begin
      mdio_out = 1'b1;
    end else begin
      mdio_out = tail[tail_pos[4:0]];
    end
  end

  assign mdio_oe = busy & ~(cmd_q.rd & (idx >= TA_IDX));
  assign rd_load = busy & fall_ev & (idx == LAST_IDX) & cmd_q.rd;
  assign rd_word = shreg;
endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
  import mdio_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        word,
  input  logic [31:0]       wdata,
  input  logic              busy,
  input  logic              rd_load,
  input  logic [DATA_W-1:0] rd_word,
  output logic [31:0]       rdata,
  output logic              start,
  output mdio_cmd_t         cmd
);
  logic [10:0]       cmd_r;
  logic [DATA_W-1:0] wdat_r;
  logic [DATA_W-1:0] rdat_r;
  logic              en_r;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[31:16];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_r  <= '0;
      wdat_r <= '0;
      rdat_r <= '0;
      en_r   <= 1'b0;
    end else begin
      if (wr && word == WORD_CMD)  cmd_r  <= wdata[10:0];
      if (wr && word == WORD_WDAT) wdat_r <= wdata[DATA_W-1:0];
      if (wr && word == WORD_CTRL) en_r   <= wdata[CTRL_EN_BIT];
      if (rd_load)                 rdat_r <= rd_word;
    end
  end

  assign start = wr & (word == WORD_CTRL) & wdata[CTRL_GO_BIT]
               & wdata[CTRL_EN_BIT] & ~busy;

  assign cmd.rd     = cmd_r[CMD_OP_BIT];
  assign cmd.phy    = cmd_r[CMD_PHY_LSB +: 5];
  assign cmd.regnum = cmd_r[4:0];
  assign cmd.wdata  = wdat_r;

  always_comb begin
    rdata = '0;
    case (word)
      WORD_CMD:  rdata[10:0]       = cmd_r;
      WORD_WDAT: rdata[DATA_W-1:0] = wdat_r;
      WORD_RDAT: rdata[DATA_W-1:0] = rdat_r;
      default: begin
        rdata[CTRL_GO_BIT] = busy;
        rdata[CTRL_EN_BIT] = en_r;
      end
    endcase
  end
endmodule

// File: rtl/mgmt_mdio_ctrl.sv
module mgmt_mdio_ctrl
  import mdio_ctrl_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 200_000_000,
  parameter int unsigned MDC_MAX_HZ = 2_500_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  localparam int unsigned HALF_RAW = (CLK_HZ + 2*MDC_MAX_HZ - 1) / (2*MDC_MAX_HZ);
  localparam int unsigned HALF     = (HALF_RAW < 2) ? 2 : HALF_RAW;

  logic              eng_busy;
  logic              start;
  logic              rise_ev;
  logic              fall_ev;
  logic              rd_load;
  logic [DATA_W-1:0] rd_word;
  mdio_cmd_t         cmd;
  logic              unused_addr_lsb;

  assign unused_addr_lsb = ^reg_addr[1:0];

  mdio_reg_bank u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .word    (reg_addr[3:2]),
    .wdata   (reg_wdata),
    .busy    (eng_busy),
    .rd_load (rd_load),
    .rd_word (rd_word),
    .rdata   (reg_rdata),
    .start   (start),
    .cmd     (cmd)
  );

  mdio_clk_div #(.HALF(HALF)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (eng_busy),
    .mdc     (mdc),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  mdio_frame_engine u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cmd_in   (cmd),
    .rise_ev  (rise_ev),
    .fall_ev  (fall_ev),
    .mdio_in  (mdio_in),
    .busy     (eng_busy),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe),
    .rd_load  (rd_load),
    .rd_word  (rd_word)
  );
endmodule

// File: rtl/mgmt_mdio_ctrl_checker.sv
module mgmt_mdio_ctrl_checker #(
  parameter int unsigned HALF = 40
) (
  input logic       clk,
  input logic       rst_n,
  input logic       mdc,
  input logic       mdio_oe,
  input logic       busy,
  input logic       reg_wr,
  input logic [1:0] reg_word,
  input logic       go_bit,
  input logic       en_bit
);
  localparam int unsigned RW = $clog2(HALF + 1);

  logic          mdc_prev;
  logic [RW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdc_prev <= 1'b0;
      run_len  <= RW'(HALF);
    end else begin
      mdc_prev <= mdc;
      if (mdc != mdc_prev)          run_len <= RW'(1);
      else if (run_len != RW'(HALF)) run_len <= run_len + 1'b1;
    end
  end

  // R1: idle bus is released and MDC parked low
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc));

  // R3: a frame only starts from an enabled go write
  a_r3_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_word == 2'd3 && go_bit && en_bit));

  // R7: every MDC level lasts at least HALF system cycles
  a_r7_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc != mdc_prev) |-> (run_len >= RW'(HALF)));

  // R7: busy ends together with the final falling MDC edge
  a_r7_end_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $fell(mdc));

  // R4: the master drives MDIO only inside a frame
  a_r4_drive_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);
endmodule

bind mgmt_mdio_ctrl mgmt_mdio_ctrl_checker #(.HALF(HALF)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mdc      (mdc),
  .mdio_oe  (mdio_oe),
  .busy     (eng_busy),
  .reg_wr   (reg_wr),
  .reg_word (reg_addr[3:2]),
  .go_bit   (reg_wdata[0]),
  .en_bit   (reg_wdata[3])
);

// File: tb/mgmt_mdio_ctrl_bench.sv
`timescale 1ns/1ps
module mgmt_mdio_ctrl_bench;
  localparam int HALF      = 4;
  localparam int FRAME_CYC = 128 * HALF;
  localparam logic [4:0] PHY = 5'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_out, mdio_oe, line;
  logic        phy_drv = 1'b0, phy_bit = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign line = mdio_oe ? mdio_out : (phy_drv ? phy_bit : 1'b1);

  mgmt_mdio_ctrl #(.CLK_HZ(200_000_000), .MDC_MAX_HZ(25_000_000)) u_mgmt_mdio_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(line)
  );

  // PHY model: memory of the device and the bench's own expectation
  logic [15:0] phy_mem [32];
  logic [15:0] shadow  [32];
  logic [63:0] cap = '0;
  int          rise_cnt = 0;
  int          total_rises = 0;
  bit          oe_lo_early = 0, oe_lo_late = 0, oe_hi_late = 0;
  bit          resp = 0;
  logic [15:0] rdv = '0;

  function automatic logic [15:0] init_val(input int i);
    return 16'hA05C ^ 16'(i * 16'h0123);
  endfunction

  function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] p,
                                             input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r,
            (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : d)};
  endfunction

  function automatic logic [15:0] exp_read(input logic [4:0] p, input logic [4:0] r);
    return (p == PHY) ? shadow[r] : 16'hFFFF;
  endfunction

  initial begin
    for (int i = 0; i < 32; i++) begin
      phy_mem[i] = init_val(i);
      shadow[i]  = init_val(i);
    end
  end

  always @(posedge mdc) begin
    if (rise_cnt == 64) begin
      rise_cnt = 0; cap = '0;
      oe_lo_early = 0; oe_lo_late = 0; oe_hi_late = 0;
    end
    cap = {cap[62:0], line};
    if (rise_cnt < 46) begin
      if (!mdio_oe) oe_lo_early = 1;
    end else begin
      if (mdio_oe) oe_hi_late = 1; else oe_lo_late = 1;
    end
    rise_cnt++;
    total_rises++;
  end

  always @(negedge mdc) begin
    if (rise_cnt == 46) begin
      resp = (cap[11:10] == 2'b10) && (cap[9:5] == PHY);
      rdv = phy_mem[cap[4:0]];
      phy_drv = 1'b0;
    end else if (rise_cnt == 47) begin
      if (resp) begin phy_drv = 1'b1; phy_bit = 1'b0; end
    end else if (rise_cnt >= 48 && rise_cnt < 64) begin
      if (resp) phy_bit = rdv[63 - rise_cnt];
    end else if (rise_cnt == 64) begin
      phy_drv = 1'b0; resp = 0;
      if (cap[29:28] == 2'b01 && cap[27:23] == PHY) phy_mem[cap[22:18]] = cap[15:0];
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_end(input int already);
    repeat (FRAME_CYC - 1 - already) @(negedge clk);
    check(reg_rdata[0] == 1'b1, "R7 busy before end", 64'(reg_rdata[0]), 64'd1);
    @(negedge clk);
    check(reg_rdata[0] == 1'b0, "R7 busy at end", 64'(reg_rdata[0]), 64'd0);
  endtask

  task automatic xfer(input bit rd, input logic [4:0] p, input logic [4:0] r,
                      input logic [15:0] d);
    logic [31:0] v;
    logic [63:0] e;
    bus_wr(4'h0, {21'h0, rd, p, r});
    bus_wr(4'h4, {16'h0, d});
    bus_wr(4'hC, 32'h9);
    check(reg_rdata == 32'h9, "R3 busy+enable readback", 64'(reg_rdata), 64'h9);
    wait_end(0);
    check(rise_cnt == 64, "R7 rising edges per frame", 64'(rise_cnt), 64'd64);
    e = exp_frame(rd, p, r, d);
    if (rd) begin
      check(cap[63:18] == e[63:18], "R5 read header", cap, e);
      check(!oe_lo_early && !oe_hi_late, "R5 oe release window",
            64'({oe_lo_early, oe_hi_late}), 64'd0);
      bus_rd(4'h8, v);
      check(v == {16'h0, exp_read(p, r)}, (p == PHY) ? "R5 read data" : "R6 absent PHY",
            64'(v), 64'(exp_read(p, r)));
    end else begin
      check(cap == e, "R4 write frame", cap, e);
      check(!oe_lo_early && !oe_lo_late, "R4 oe held",
            64'({oe_lo_early, oe_lo_late}), 64'd0);
      if (p == PHY) shadow[r] = d;
    end
  endtask

  initial begin
    logic [31:0] v;
    int          n;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1
    for (int a = 0; a < 4; a++) begin
      bus_rd(4'(a * 4), v);
      check(v == 32'h0, "R1 reset register", 64'(v), 64'h0);
    end
    check(!mdc && !mdio_oe, "R1 pins idle", 64'({mdc, mdio_oe}), 64'h0);
    // R2
    bus_wr(4'h0, 32'hFFFF_FFFF); bus_rd(4'h0, v);
    check(v == 32'h7FF, "R2 command mask", 64'(v), 64'h7FF);
    bus_wr(4'h4, 32'hFFFF_FFFF); bus_rd(4'h4, v);
    check(v == 32'hFFFF, "R2 write data mask", 64'(v), 64'hFFFF);
    bus_wr(4'h8, 32'h1234_5678); bus_rd(4'h8, v);
    check(v == 32'h0, "R2 read data read-only", 64'(v), 64'h0);
    // R9
    n = total_rises;
    bus_wr(4'hC, 32'h1);
    check(reg_rdata == 32'h0, "R9 no start without enable", 64'(reg_rdata), 64'h0);
    repeat (40) @(negedge clk);
    check(total_rises == n && !mdc, "R9 MDC quiet", 64'(total_rises), 64'(n));
    // directed R4 R5 R6
    xfer(1'b0, PHY, 5'd5, 16'h8001);
    xfer(1'b1, PHY, 5'd5, 16'h0);
    xfer(1'b1, 5'd0, 5'd3, 16'h0);
    xfer(1'b1, 5'd31, 5'd31, 16'h0);
    // random mix
    for (int k = 0; k < 10; k++) begin
      logic [4:0] p;
      p = ($urandom % 3 == 0) ? 5'($urandom) : PHY;
      xfer(1'($urandom), p, 5'($urandom), 16'($urandom));
    end
    // R8
    bus_wr(4'h0, {21'h0, 1'b1, PHY, 5'd2});
    bus_wr(4'hC, 32'h9);
    repeat (100) @(negedge clk);
    bus_wr(4'h0, {21'h0, 1'b0, 5'd3, 5'd9});
    bus_wr(4'hC, 32'h9);
    wait_end(104);
    check(cap[63:18] == exp_frame(1'b1, PHY, 5'd2, 16'h0) >> 18 << 18 >> 18 ? 1'b1 : 1'b0,
          "R8 header kept", cap, exp_frame(1'b1, PHY, 5'd2, 16'h0));
    bus_rd(4'h8, v);
    check(v == {16'h0, shadow[2]}, "R8 first command result", 64'(v), 64'(shadow[2]));
    n = total_rises;
    repeat (40) @(negedge clk);
    check(total_rises == n && reg_rdata[0] == 1'b0, "R8 no second frame",
          64'(total_rises), 64'(n));
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule